// File: doc/BRIEF.md
# Zero-Overhead Loop Program Sequencer

This block computes the program fetch address of a fixed-point DSP core, one address per cycle, over a 14-bit program space. The core decodes each instruction and presents its control fields: an operation code, a 4-bit condition code, a target address and a loop count. It also supplies the live arithmetic status flags. The sequencer picks the next address from four sources: the incremented address, the branch target, the top of the return stack, or the loop top. Every choice costs exactly one cycle and never stalls.

Hardware loops are started by a loop-entry operation. It saves the loop top (entry address + 1) on the return stack. It saves the loop end address and the termination condition on a loop stack, and the outer loop counter on a counter stack, then loads the new count. When the fetch address reaches the loop end, the sequencer either returns to the loop top and decrements the counter, or leaves the loop and pops all three stacks. No branch instruction is needed and no cycle is added. A push onto a full stack or a pop from an empty stack is refused and recorded in a sticky flag.

Top module: `zol_seq`

## Requirements
- R1: After reset, fetch_addr_o is 0, cntr_o is 0 and ovf_o and unf_o are 3'b000. Flag bit 0 is the return stack, bit 1 the loop stack and bit 2 the counter stack.
- R2: With op_i = 0 (no flow change; codes 5 to 7 act the same), and outside a loop end, the next fetch address is the current one plus 1, wrapping modulo 2^14.
- R3: With op_i = 1 (jump), the next address is target_i when the condition holds, else the current address plus 1. The condition codes are: 0 zero, 1 not zero, 2 negative, 3 not negative, 4 carry, 5 no carry, 6 overflow, 7 no overflow, 8 neither zero nor negative, 9 zero or negative, 10 to 13 never, 14 counter equals 1, 15 always. flags_i bits are [0] zero, [1] negative, [2] carry, [3] overflow.
- R4: A taken call (op_i = 2) jumps to target_i and pushes the current address plus 1 in the same cycle. A taken return (op_i = 3) jumps to the popped address in the same cycle. An untaken call or return behaves as op_i = 0.
- R5: Loop entry (op_i = 4) continues at the current address plus 1. It pushes that address on the return stack, pushes {cond_i, target_i} as loop end and termination condition, pushes the current counter, and loads count_i into the counter.
- R6: When the fetch address equals the innermost loop end and its termination condition is false, the next address is the top of the return stack and the counter decrements, with no extra cycle.
- R7: When the termination condition is true at the loop end, the next address is the loop end plus 1. All three stacks are popped and the saved outer counter is restored, so nested loops resume correctly.
- R8: A loop entered with condition 14 and count N (N >= 1) runs its body N times.
- R9: A taken jump, call or return, or a loop entry, placed at the loop end address takes precedence. The loop-end action is skipped and the counter stays unchanged.
- R10: A push onto a full stack sets the sticky overflow flag of that stack and leaves the stored entries intact. A call still jumps. A loop entry with any stack full pushes nothing and leaves the counter unchanged.
- R11: A pop from an empty stack sets the sticky underflow flag of that stack. A taken return on an empty return stack continues at the current address plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Flow operation of the instruction at fetch_addr_o |
| cond_i | input | 4 | Condition code for branch, or termination code for loop entry |
| flags_i | input | 4 | Status flags {overflow, carry, negative, zero} |
| target_i | input | 14 | Branch target, or loop end address for loop entry |
| count_i | input | 14 | Iteration count for loop entry |
| fetch_addr_o | output | 14 | Current fetch address |
| cntr_o | output | 14 | Active loop counter |
| ovf_o | output | 3 | Sticky overflow flags {counter, loop, return} |
| unf_o | output | 3 | Sticky underflow flags {counter, loop, return} |

## Verification
The interesting overlap is a flow-change instruction sitting at the loop end address, where the loop-back decision and the jump decision fall in one cycle. The bench places an always-taken jump at the end of a two-pass loop. It expects the jump target with the counter unchanged, and then a normal loop-back and exit on the following passes. Nested loops whose inner end is one before the outer end are also run, so an inner exit leads straight into an outer loop-end decision on the next cycle. Random streams that put loop entries and branches near active loop ends are compared cycle by cycle against the bench model.

// File: rtl/zol_seq_pkg.sv
package zol_seq_pkg;
  localparam int unsigned SEQ_AW = 14;
  localparam int unsigned SEQ_CW = 14;

  localparam logic [2:0] OP_NONE = 3'd0;
  localparam logic [2:0] OP_JUMP = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_LOOP = 3'd4;

  localparam logic [3:0] CC_CNT_ONE = 4'd14;
  localparam logic [3:0] CC_ALWAYS  = 4'd15;

  // flag bit positions
  localparam int unsigned FL_Z = 0;
  localparam int unsigned FL_N = 1;
  localparam int unsigned FL_C = 2;
  localparam int unsigned FL_V = 3;
endpackage

// File: rtl/zol_cond.sv
module zol_cond
  import zol_seq_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic [3:0] flags_i,
  input  logic       cnt_one_i,
  output logic       true_o
);
  logic z, n, c, v;
  assign z = flags_i[FL_Z];
  assign n = flags_i[FL_N];
  assign c = flags_i[FL_C];
  assign v = flags_i[FL_V];

  always_comb begin
    case (code_i)
      4'd0:       true_o = z;
      4'd1:       true_o = !z;
      4'd2:       true_o = n;
      4'd3:       true_o = !n;
      4'd4:       true_o = c;
      4'd5:       true_o = !c;
      4'd6:       true_o = v;
      4'd7:       true_o = !v;
      4'd8:       true_o = !z && !n;
      4'd9:       true_o = z || n;
      CC_CNT_ONE: true_o = cnt_one_i;
      CC_ALWAYS:  true_o = 1'b1;
      default:    true_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/zol_stack.sv
module zol_stack #(
  parameter int unsigned W     = 14,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp_q;
  logic [PW-1:0] top_idx;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == PW'(DEPTH));
  assign top_idx = sp_q - PW'(1);
  assign top_o   = mem[top_idx[IW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sp_q <= '0;
    else if (push_i && !full_o)   sp_q <= sp_q + PW'(1);
    else if (pop_i && !empty_o)   sp_q <= sp_q - PW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[sp_q[IW-1:0]] <= din_i;
  end
endmodule

// File: rtl/zol_seq.sv
module zol_seq
  import zol_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = SEQ_AW,
  parameter int unsigned CNT_W      = SEQ_CW,
  parameter int unsigned PC_DEPTH   = 16,
  parameter int unsigned LOOP_DEPTH = 4,
  parameter int unsigned CNT_DEPTH  = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [CNT_W-1:0]  cntr_o,
  output logic [2:0]        ovf_o,
  output logic [2:0]        unf_o
);
  localparam int unsigned LW = ADDR_W + 4;

  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
  logic [CNT_W-1:0]  cntr_q, cntr_d;
  logic [2:0]        ovf_q, unf_q, ovf_set, unf_set;

  logic [ADDR_W-1:0] pc_top;
  logic              pc_full, pc_empty, pc_push, pc_pop;
  logic [LW-1:0]     lp_top, lp_din;
  logic              loop_full, loop_empty, lp_push, lp_pop;
  logic [CNT_W-1:0]  cs_top;
  logic              cs_full, cs_empty, cs_push, cs_pop;

  logic [ADDR_W-1:0] loop_end_top;
  logic [3:0]        loop_cond;
  logic              cnt_one, op_true, term_true;
  logic              acted, at_end, loop_back;

  assign pc_inc       = pc_q + ADDR_W'(1);
  assign loop_end_top = lp_top[ADDR_W-1:0];
  assign loop_cond    = lp_top[LW-1 -: 4];
  assign lp_din       = {cond_i, target_i};
  assign cnt_one      = (cntr_q == CNT_W'(1));

  zol_cond u_cond_op (
    .code_i(cond_i), .flags_i(flags_i), .cnt_one_i(cnt_one), .true_o(op_true)
  );
  zol_cond u_cond_loop (
    .code_i(loop_cond), .flags_i(flags_i), .cnt_one_i(cnt_one), .true_o(term_true)
  );

  zol_stack #(.W(ADDR_W), .DEPTH(PC_DEPTH)) u_pc_stack (
    .clk_i, .rst_ni, .push_i(pc_push), .pop_i(pc_pop), .din_i(pc_inc),
    .top_o(pc_top), .empty_o(pc_empty), .full_o(pc_full)
  );
  zol_stack #(.W(LW), .DEPTH(LOOP_DEPTH)) u_loop_stack (
    .clk_i, .rst_ni, .push_i(lp_push), .pop_i(lp_pop), .din_i(lp_din),
    .top_o(lp_top), .empty_o(loop_empty), .full_o(loop_full)
  );
  zol_stack #(.W(CNT_W), .DEPTH(CNT_DEPTH)) u_cnt_stack (
    .clk_i, .rst_ni, .push_i(cs_push), .pop_i(cs_pop), .din_i(cntr_q),
    .top_o(cs_top), .empty_o(cs_empty), .full_o(cs_full)
  );

  always_comb begin
    pc_d = pc_inc;  cntr_d = cntr_q;
    pc_push = 1'b0; pc_pop = 1'b0;
    lp_push = 1'b0; lp_pop = 1'b0;
    cs_push = 1'b0; cs_pop = 1'b0;
    ovf_set = '0;   unf_set = '0;
    acted = 1'b0;   loop_back = 1'b0;

    case (op_i)
      OP_JUMP: if (op_true) begin
        acted = 1'b1;
        pc_d  = target_i;
      end
      OP_CALL: if (op_true) begin
        acted = 1'b1;
        pc_d  = target_i;
        if (pc_full) ovf_set[0] = 1'b1;
        else         pc_push    = 1'b1;
      end
      OP_RET: if (op_true) begin
        acted = 1'b1;
        if (pc_empty) unf_set[0] = 1'b1;
        else begin
          pc_d   = pc_top;
          pc_pop = 1'b1;
        end
      end
      OP_LOOP: begin
        acted = 1'b1;
        // all-or-nothing entry keeps the three stacks aligned
        if (pc_full || loop_full || cs_full) begin
          ovf_set = {cs_full, loop_full, pc_full};
        end else begin
          pc_push = 1'b1;
          lp_push = 1'b1;
          cs_push = 1'b1;
          cntr_d  = count_i;
        end
      end
      default: ;
    endcase

    at_end = !loop_empty && (pc_q == loop_end_top);
    if (!acted && at_end) begin
      if (!term_true) begin
        cntr_d = cntr_q - CNT_W'(1);
        if (pc_empty) unf_set[0] = 1'b1;
        else begin
          pc_d      = pc_top;
          loop_back = 1'b1;
        end
      end else begin
        lp_pop = 1'b1;
        if (pc_empty) unf_set[0] = 1'b1;
        else          pc_pop     = 1'b1;
        if (cs_empty) unf_set[2] = 1'b1;
        else begin
          cs_pop = 1'b1;
          cntr_d = cs_top;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_ADDR;
      cntr_q <= '0;
      ovf_q  <= '0;
      unf_q  <= '0;
    end else begin
      pc_q   <= pc_d;
      cntr_q <= cntr_d;
      ovf_q  <= ovf_q | ovf_set;
      unf_q  <= unf_q | unf_set;
    end
  end

  assign fetch_addr_o = pc_q;
  assign cntr_o       = cntr_q;
  assign ovf_o        = ovf_q;
  assign unf_o        = unf_q;
endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned CNT_W  = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [3:0]        cond_i,
  input logic [ADDR_W-1:0] target_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [CNT_W-1:0]  cntr_o,
  input logic [2:0]        ovf_o,
  input logic [2:0]        unf_o,
  input logic              loop_empty,
  input logic [ADDR_W-1:0] loop_end_top,
  input logic [ADDR_W-1:0] pc_top,
  input logic              pc_full,
  input logic              loop_back
);
  assert_seq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 && (loop_empty || fetch_addr_o != loop_end_top))
      |=> fetch_addr_o == ADDR_W'($past(fetch_addr_o) + ADDR_W'(1)));

  assert_jump_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && cond_i == 4'd15) |=> fetch_addr_o == $past(target_i));

  assert_call_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && cond_i == 4'd15 && !pc_full)
      |=> pc_top == ADDR_W'($past(fetch_addr_o) + ADDR_W'(1)));

  assert_loop_back_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_back |=> (fetch_addr_o == $past(pc_top)) && (cntr_o == CNT_W'($past(cntr_o) - CNT_W'(1))));

  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o & $past(ovf_o)) == $past(ovf_o));

  assert_unf_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_o & $past(unf_o)) == $past(unf_o));
endmodule

bind zol_seq zol_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/zol_seq_bench.sv
module zol_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [3:0]  cond_i = '0;
  logic [3:0]  flags_i = '0;
  logic [13:0] target_i = '0;
  logic [13:0] count_i = '0;
  logic [13:0] fetch_addr_o, cntr_o;
  logic [2:0]  ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  zol_seq u_zol_seq (.*);

  // reference model state
  logic [13:0] m_pc, m_cntr;
  logic [2:0]  m_ovf, m_unf;
  logic [13:0] m_pcs [16];
  logic [13:0] m_le  [4];
  logic [3:0]  m_lc  [4];
  logic [13:0] m_cs  [4];
  int m_psp, m_lsp, m_csp;

  function automatic bit m_cond(input logic [3:0] code, input logic [3:0] fl, input logic [13:0] cnt);
    case (code)
      4'd0: return fl[0];
      4'd1: return !fl[0];
      4'd2: return fl[1];
      4'd3: return !fl[1];
      4'd4: return fl[2];
      4'd5: return !fl[2];
      4'd6: return fl[3];
      4'd7: return !fl[3];
      4'd8: return !fl[0] && !fl[1];
      4'd9: return fl[0] || fl[1];
      4'd14: return cnt == 14'd1;
      4'd15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic m_reset();
    m_pc = '0; m_cntr = '0; m_ovf = '0; m_unf = '0;
    m_psp = 0; m_lsp = 0; m_csp = 0;
  endtask

  task automatic m_step(input logic [2:0] op, input logic [3:0] cond, input logic [13:0] tgt,
                        input logic [13:0] cnt, input logic [3:0] fl);
    logic [13:0] inc, nxt, ncnt;
    bit t, acted, term;
    inc = m_pc + 14'd1; nxt = inc; ncnt = m_cntr; acted = 0;
    t = m_cond(cond, fl, m_cntr);
    case (op)
      3'd1: if (t) begin acted = 1; nxt = tgt; end
      3'd2: if (t) begin
        acted = 1; nxt = tgt;
        if (m_psp == 16) m_ovf[0] = 1'b1;
        else begin m_pcs[m_psp] = inc; m_psp++; end
      end
      3'd3: if (t) begin
        acted = 1;
        if (m_psp == 0) m_unf[0] = 1'b1;
        else begin m_psp--; nxt = m_pcs[m_psp]; end
      end
      3'd4: begin
        acted = 1;
        if (m_psp == 16 || m_lsp == 4 || m_csp == 4) begin
          m_ovf = m_ovf | {m_csp == 4, m_lsp == 4, m_psp == 16};
        end else begin
          m_pcs[m_psp] = inc; m_psp++;
          m_le[m_lsp] = tgt; m_lc[m_lsp] = cond; m_lsp++;
          m_cs[m_csp] = m_cntr; m_csp++;
          ncnt = cnt;
        end
      end
      default: ;
    endcase
    if (!acted && m_lsp > 0 && m_pc == m_le[m_lsp-1]) begin
      term = m_cond(m_lc[m_lsp-1], fl, m_cntr);
      if (!term) begin
        ncnt = m_cntr - 14'd1;
        if (m_psp == 0) m_unf[0] = 1'b1;
        else nxt = m_pcs[m_psp-1];
      end else begin
        m_lsp--;
        if (m_psp == 0) m_unf[0] = 1'b1; else m_psp--;
        if (m_csp == 0) m_unf[2] = 1'b1;
        else begin m_csp--; ncnt = m_cs[m_csp]; end
      end
    end
    m_pc = nxt; m_cntr = ncnt;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (fetch_addr_o !== m_pc || cntr_o !== m_cntr || ovf_o !== m_ovf || unf_o !== m_unf) begin
      errors++;
      $display("FAIL %s: pc=%0d cnt=%0d ovf=%b unf=%b expected pc=%0d cnt=%0d ovf=%b unf=%b",
               tag, fetch_addr_o, cntr_o, ovf_o, unf_o, m_pc, m_cntr, m_ovf, m_unf);
    end
  endtask

  task automatic expect_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called just after a falling edge; result checked at the next falling edge
  task automatic step(input logic [2:0] op, input logic [3:0] cond, input logic [13:0] tgt,
                      input logic [13:0] cnt, input logic [3:0] fl, input string tag);
    op_i = op; cond_i = cond; target_i = tgt; count_i = cnt; flags_i = fl;
    m_step(op, cond, tgt, cnt, fl);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic nop(input string tag);
    step(3'd0, 4'd0, 14'd0, 14'd0, 4'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    compare("R1 reset state");
    expect_val("R1 reset pc", int'(fetch_addr_o), 0);

    // R5/R6/R7/R8: loop 1..3, three passes
    step(3'd4, 4'd14, 14'd3, 14'd3, 4'd0, "R5 loop entry");
    expect_val("R5 counter loaded", int'(cntr_o), 3);
    begin
      int exp_pc[9] = '{2, 3, 1, 2, 3, 1, 2, 3, 4};
      for (int i = 0; i < 9; i++) begin
        nop("R6 loop body");
        expect_val(i == 8 ? "R8 loop exit after N passes" : "R6 zero-overhead loop-back",
                   int'(fetch_addr_o), exp_pc[i]);
      end
    end
    expect_val("R7 counter restored", int'(cntr_o), 0);

    // R4 call / return
    step(3'd2, 4'd15, 14'd20, 14'd0, 4'd0, "R4 call");
    expect_val("R4 call target", int'(fetch_addr_o), 20);
    nop("R2 increment");
    step(3'd3, 4'd15, 14'd0, 14'd0, 4'd0, "R4 return");
    expect_val("R4 return address", int'(fetch_addr_o), 5);
    step(3'd3, 4'd0, 14'd0, 14'd0, 4'd0, "R4 untaken return");
    expect_val("R4 untaken return", int'(fetch_addr_o), 6);

    // R3 conditional jumps, zero flag set
    step(3'd1, 4'd0, 14'd40, 14'd0, 4'b0001, "R3 jump on zero");
    expect_val("R3 taken jump", int'(fetch_addr_o), 40);
    step(3'd1, 4'd1, 14'd50, 14'd0, 4'b0001, "R3 jump on not zero");
    expect_val("R3 untaken jump", int'(fetch_addr_o), 41);

    // R9 jump at loop end wins
    step(3'd4, 4'd14, 14'd43, 14'd2, 4'd0, "R9 loop entry");
    nop("R9 body");
    step(3'd1, 4'd15, 14'd42, 14'd0, 4'd0, "R9 jump at end");
    expect_val("R9 jump target at loop end", int'(fetch_addr_o), 42);
    expect_val("R9 counter unchanged", int'(cntr_o), 2);
    nop("R9 body"); nop("R6 loop-back");
    expect_val("R6 loop-back after jump", int'(fetch_addr_o), 42);
    expect_val("R6 counter decrement", int'(cntr_o), 1);
    nop("R9 body"); nop("R7 exit");
    expect_val("R7 exit address", int'(fetch_addr_o), 44);

    // R7 nested loops
    step(3'd4, 4'd14, 14'd47, 14'd2, 4'd0, "R7 outer entry");
    step(3'd4, 4'd14, 14'd46, 14'd2, 4'd0, "R7 inner entry");
    nop("R7 inner pass");
    nop("R7 inner exit");
    expect_val("R7 outer counter restored", int'(cntr_o), 2);
    nop("R7 outer loop-back");
    expect_val("R7 outer loop top", int'(fetch_addr_o), 45);
    step(3'd4, 4'd14, 14'd46, 14'd2, 4'd0, "R7 inner re-entry");
    nop("R7 inner pass"); nop("R7 inner exit"); nop("R7 outer exit");
    expect_val("R7 nested exit address", int'(fetch_addr_o), 48);

    // R10 overflow, R11 underflow
    for (int i = 0; i < 16; i++)
      step(3'd2, 4'd15, 14'(100 + i), 14'd0, 4'd0, "R4 deep call");
    expect_val("R10 no overflow at depth", int'(ovf_o), 0);
    step(3'd4, 4'd14, 14'd120, 14'd5, 4'd0, "R10 loop entry on full stack");
    expect_val("R10 refused loop entry flags", int'(ovf_o), 1);
    expect_val("R10 counter untouched", int'(cntr_o), 0);
    step(3'd2, 4'd15, 14'd200, 14'd0, 4'd0, "R10 call on full stack");
    expect_val("R10 call still jumps", int'(fetch_addr_o), 200);
    step(3'd3, 4'd15, 14'd0, 14'd0, 4'd0, "R10 entries intact");
    expect_val("R10 top entry intact", int'(fetch_addr_o), 115);
    for (int i = 0; i < 15; i++)
      step(3'd3, 4'd15, 14'd0, 14'd0, 4'd0, "R10 unwind");
    expect_val("R10 bottom entry intact", int'(fetch_addr_o), 49);
    step(3'd3, 4'd15, 14'd0, 14'd0, 4'd0, "R11 return on empty");
    expect_val("R11 return on empty continues", int'(fetch_addr_o), 50);
    expect_val("R11 underflow flag", int'(unf_o), 1);

    // fresh reset then constrained random
    @(negedge clk_i);
    rst_ni = 1'b0; m_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    compare("R1 second reset");
    void'($urandom(32'h5eed_0c1a));
    for (int i = 0; i < 4000; i++) begin
      int sel = int'($urandom % 16);
      logic [2:0]  op;
      logic [13:0] tgt;
      string tag;
      if (sel < 7)       begin op = 3'd0; tag = "R2 random"; end
      else if (sel < 9)  begin op = 3'd1; tag = "R3 random"; end
      else if (sel < 11) begin op = 3'd2; tag = "R4 random"; end
      else if (sel < 13) begin op = 3'd3; tag = "R4 random"; end
      else               begin op = 3'd4; tag = "R6 random"; end
      if (op == 3'd4) tgt = m_pc + 14'(1 + $urandom % 6);
      else            tgt = 14'($urandom % 64);
      step(op, 4'($urandom), tgt, 14'(1 + $urandom % 4), 4'($urandom), tag);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule